// File: doc/BRIEF.md
# SPI Byte Buffers with Threshold Interrupts

This block sits between a host register interface and the serial shifter of an SPI controller. It holds two byte-wide queues of 64 entries each: an outbound queue that the host fills and the shifter drains, and an inbound queue that the shifter fills and the host drains. Each queue is run by a small fill-state machine with three states: `FS_EMPTY`, `FS_PARTIAL` and `FS_FULL`. The state decides whether a push or a pop is accepted. The transitions are as follows. A push moves `FS_EMPTY` to `FS_PARTIAL`. A push that brings the count to the depth moves `FS_PARTIAL` to `FS_FULL`. A pop that brings the count to zero moves `FS_PARTIAL` to `FS_EMPTY`. A pop moves `FS_FULL` to `FS_PARTIAL`. A flush strobe moves any state to `FS_EMPTY`.

Beside the queues, an interrupt unit keeps three sticky status flags:
- an inbound flag, raised while the inbound queue holds at least three quarters of its depth;
- an outbound flag, raised while the outbound queue holds at most one quarter of its depth;
- a completion flag, raised by a one-cycle pulse from the shifter when a transfer ends.

Writing ones to the status word clears the flags. A single interrupt line is the OR of the flags, each gated by its enable bit. Both queue occupancies are packed into one status word for the host to read.

Top module: `spi_buf_irq`

## Requirements
- R1: While reset is held, the FIFO status word, the interrupt status word and the interrupt line are all zero.
- R2: Each queue returns bytes in the order they were accepted and holds up to 64 of them. A host read or shifter take advances to the next byte in the cycle after it is issued.
- R3: A host write while the outbound queue holds 64 bytes and no take occurs is dropped. A host read of an empty inbound queue changes nothing. The read data port shows 0 while the inbound queue is empty, and the take data port shows 0 while the outbound queue is empty.
- R4: The FIFO status word carries the inbound count in bits 6:0 and the outbound count in bits 22:16. All its other bits are zero. Counts update in the cycle after the push or pop.
- R5: Status bit 4 is set in the cycle after a clock edge at which the inbound count is 48 or more.
- R6: Status bit 12 is set in the cycle after a clock edge at which the outbound count is 16 or fewer.
- R7: Status bit 16 is set in the cycle after a completion pulse and stays set until cleared. A completion pulse in the same cycle as a clear of bit 16 leaves it set.
- R8: Writing a one to status bit 4, 12 or 16 clears that bit on the next edge, and a zero leaves it unchanged. Writing all ones clears every flag. A threshold flag cleared while its condition still holds reads 0 for one cycle and then 1 again.
- R9: A flush strobe empties only its own queue, with the count reading 0 in the next cycle. A write to the same queue in the flush cycle is discarded.
- R10: The enable word keeps only bits 4, 12 and 16. The interrupt line is high exactly when some status bit and its enable bit are both set.
- R11: A push and a pop on the same cycle to a queue that is neither empty nor full leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr_en | input | 1 | Host writes a byte into the outbound queue |
| host_wr_data | input | 8 | Byte written by the host |
| host_rd_en | input | 1 | Host pops the inbound queue |
| host_rd_data | output | 8 | Head of the inbound queue, 0 when empty |
| shf_tx_take | input | 1 | Shifter pops the outbound queue |
| shf_tx_data | output | 8 | Head of the outbound queue, 0 when empty |
| shf_rx_put | input | 1 | Shifter pushes a received byte |
| shf_rx_data | input | 8 | Byte pushed by the shifter |
| xfer_done | input | 1 | One-cycle transfer completion pulse |
| tx_flush | input | 1 | Empties the outbound queue |
| rx_flush | input | 1 | Empties the inbound queue |
| irq_en_wr | input | 1 | Loads the enable word |
| irq_en_data | input | 32 | New enable word |
| sts_clr_wr | input | 1 | Write-one-to-clear strobe for the status word |
| sts_clr_data | input | 32 | Bits to clear |
| irq_status | output | 32 | Flags: bit 4 inbound high, bit 12 outbound low, bit 16 completion |
| fifo_status | output | 32 | Inbound count in bits 6:0, outbound count in bits 22:16 |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the following:
- the queue count stays within bounds;
- dropped pushes and pops leave the count unchanged;
- a balanced push and pop leaves the count unchanged;
- a flush empties the queue;
- each flag sets from its condition, and a one in the clear word clears it.

Several behaviours depend on an order of events or on data values, and only the bench's scenarios can show them:
- byte order through each queue;
- zero data on empty heads;
- a threshold flag coming back one cycle after it is cleared;
- completion winning over a clear in the same cycle;
- the interrupt line following the enable mask.

A behavioural queue model compares every output on every cycle, including during a long stretch of random traffic.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    // Status and enable bit positions (decoded by host software)
    localparam int STS_RX_HI_BIT = 4;
    localparam int STS_TX_LO_BIT = 12;
    localparam int STS_DONE_BIT  = 16;

    // Occupancy field offsets in the FIFO status word
    localparam int RX_CNT_LSB = 0;
    localparam int TX_CNT_LSB = 16;

    localparam logic [31:0] STS_IMPL_MASK = (32'd1 << STS_RX_HI_BIT)
                                          | (32'd1 << STS_TX_LO_BIT)
                                          | (32'd1 << STS_DONE_BIT);

    typedef enum logic [1:0] {
        FS_EMPTY,
        FS_PARTIAL,
        FS_FULL
    } fill_state_e;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
    import spi_buf_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt
);

    fill_state_e   st_q, st_d;
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          push_ok, pop_ok;
    logic [W-1:0]  mem [DEPTH];

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Acceptance decided by fill state
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        unique case (st_q)
            FS_EMPTY:   push_ok = push;
            FS_PARTIAL: begin
                push_ok = push;
                pop_ok  = pop;
            end
            FS_FULL:    pop_ok = pop;
            default:    ;
        endcase
        if (flush) begin
            push_ok = 1'b0;
            pop_ok  = 1'b0;
        end
    end

    always_comb begin
        if (flush) begin
            cnt_d = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_d = cnt_q + CW'(1);
                2'b01:   cnt_d = cnt_q - CW'(1);
                default: cnt_d = cnt_q;
            endcase
        end
        if (cnt_d == '0)
            st_d = FS_EMPTY;
        else if (cnt_d == CW'(DEPTH))
            st_d = FS_FULL;
        else
            st_d = FS_PARTIAL;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FS_EMPTY;
            cnt_q <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (flush) begin
                wp_q <= '0;
                rp_q <= '0;
            end else begin
                if (push_ok) wp_q <= ptr_next(wp_q);
                if (pop_ok)  rp_q <= ptr_next(rp_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= push_data;
    end

    // Outputs
    always_comb begin
        head = (st_q == FS_EMPTY) ? '0 : mem[rp_q];
        cnt  = cnt_q;
    end

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(DEPTH) && push && !pop && !flush) |=> cnt_q == CW'(DEPTH));

    a_r3_empty_pop_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && pop && !push && !flush) |=> cnt_q == '0);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> cnt_q == '0);

    a_r11_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush && cnt_q != '0 && cnt_q != CW'(DEPTH)) |=> $stable(cnt_q));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import spi_buf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int RX_HI = (DEPTH * 3) / 4,
    localparam int TX_LO = DEPTH / 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] tx_cnt,
    input  logic          done,
    input  logic          clr_wr,
    input  logic [31:0]   clr_data,
    input  logic          en_wr,
    input  logic [31:0]   en_data,
    output logic [31:0]   sts,
    output logic          irq
);

    logic [31:0] sts_q, en_q, clr;
    logic        rx_hi, tx_lo;

    always_comb begin
        clr   = clr_wr ? (clr_data & STS_IMPL_MASK) : '0;
        rx_hi = rx_cnt >= CW'(RX_HI);
        tx_lo = tx_cnt <= CW'(TX_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            // Threshold flags: clear has priority, condition re-sets later
            if (clr[STS_RX_HI_BIT])      sts_q[STS_RX_HI_BIT] <= 1'b0;
            else if (rx_hi)              sts_q[STS_RX_HI_BIT] <= 1'b1;
            if (clr[STS_TX_LO_BIT])      sts_q[STS_TX_LO_BIT] <= 1'b0;
            else if (tx_lo)              sts_q[STS_TX_LO_BIT] <= 1'b1;
            // Completion: the event wins over a clear
            if (done)                    sts_q[STS_DONE_BIT] <= 1'b1;
            else if (clr[STS_DONE_BIT])  sts_q[STS_DONE_BIT] <= 1'b0;
            if (en_wr) en_q <= en_data & STS_IMPL_MASK;
        end
    end

    always_comb begin
        sts = sts_q;
        irq = |(sts_q & en_q);
    end

    a_r5_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt >= CW'(RX_HI) && !(clr_wr && clr_data[STS_RX_HI_BIT])) |=> sts[STS_RX_HI_BIT]);

    a_r6_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(TX_LO) && !(clr_wr && clr_data[STS_TX_LO_BIT])) |=> sts[STS_TX_LO_BIT]);

    a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> sts[STS_DONE_BIT]);

    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[STS_DONE_BIT] && !(clr_wr && clr_data[STS_DONE_BIT])) |=> sts[STS_DONE_BIT]);

    a_r8_clear_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[STS_RX_HI_BIT]) |=> !sts[STS_RX_HI_BIT]);

    a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[STS_DONE_BIT] && !done) |=> !sts[STS_DONE_BIT]);

endmodule

// File: rtl/spi_buf_irq.sv
module spi_buf_irq
    import spi_buf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_en,
    input  logic [7:0]  host_wr_data,
    input  logic        host_rd_en,
    output logic [7:0]  host_rd_data,
    input  logic        shf_tx_take,
    output logic [7:0]  shf_tx_data,
    input  logic        shf_rx_put,
    input  logic [7:0]  shf_rx_data,
    input  logic        xfer_done,
    input  logic        tx_flush,
    input  logic        rx_flush,
    input  logic        irq_en_wr,
    input  logic [31:0] irq_en_data,
    input  logic        sts_clr_wr,
    input  logic [31:0] sts_clr_data,
    output logic [31:0] irq_status,
    output logic [31:0] fifo_status,
    output logic        irq
);

    logic [CW-1:0] tx_cnt, rx_cnt;

    byte_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (host_wr_en),
        .push_data (host_wr_data),
        .pop       (shf_tx_take),
        .head      (shf_tx_data),
        .cnt       (tx_cnt)
    );

    byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (shf_rx_put),
        .push_data (shf_rx_data),
        .pop       (host_rd_en),
        .head      (host_rd_data),
        .cnt       (rx_cnt)
    );

    irq_ctrl #(.DEPTH(DEPTH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_cnt   (rx_cnt),
        .tx_cnt   (tx_cnt),
        .done     (xfer_done),
        .clr_wr   (sts_clr_wr),
        .clr_data (sts_clr_data),
        .en_wr    (irq_en_wr),
        .en_data  (irq_en_data),
        .sts      (irq_status),
        .irq      (irq)
    );

    always_comb begin
        fifo_status = (32'(rx_cnt) << RX_CNT_LSB) | (32'(tx_cnt) << TX_CNT_LSB);
    end

endmodule

// File: tb/spi_buf_irq_test.sv
`timescale 1ns/100ps
module spi_buf_irq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 0, host_rd_en = 0, shf_tx_take = 0, shf_rx_put = 0;
    logic        xfer_done = 0, tx_flush = 0, rx_flush = 0, irq_en_wr = 0, sts_clr_wr = 0;
    logic [7:0]  host_wr_data = 0, shf_rx_data = 0;
    logic [31:0] irq_en_data = 0, sts_clr_data = 0;
    logic [7:0]  host_rd_data, shf_tx_data;
    logic [31:0] irq_status, fifo_status;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit fin   = 0;

    always #2.5 clk = ~clk;

    spi_buf_irq uut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .shf_tx_take(shf_tx_take), .shf_tx_data(shf_tx_data),
        .shf_rx_put(shf_rx_put), .shf_rx_data(shf_rx_data),
        .xfer_done(xfer_done), .tx_flush(tx_flush), .rx_flush(rx_flush),
        .irq_en_wr(irq_en_wr), .irq_en_data(irq_en_data),
        .sts_clr_wr(sts_clr_wr), .sts_clr_data(sts_clr_data),
        .irq_status(irq_status), .fifo_status(fifo_status), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [31:0] m_sts, m_en;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txq.delete();
            rxq.delete();
            m_sts = 0;
            m_en  = 0;
        end else begin
            int ots, ors;
            ots = txq.size();
            ors = rxq.size();
            if (sts_clr_wr && sts_clr_data[4])  m_sts[4] = 0;
            else if (ors >= 48)                 m_sts[4] = 1;
            if (sts_clr_wr && sts_clr_data[12]) m_sts[12] = 0;
            else if (ots <= 16)                 m_sts[12] = 1;
            if (xfer_done)                      m_sts[16] = 1;
            else if (sts_clr_wr && sts_clr_data[16]) m_sts[16] = 0;
            if (irq_en_wr) m_en = irq_en_data & 32'h0001_1010;
            if (tx_flush) txq.delete();
            else begin
                if (shf_tx_take && ots > 0) void'(txq.pop_front());
                if (host_wr_en && ots < 64) txq.push_back(host_wr_data);
            end
            if (rx_flush) rxq.delete();
            else begin
                if (host_rd_en && ors > 0) void'(rxq.pop_front());
                if (shf_rx_put && ors < 64) rxq.push_back(shf_rx_data);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R4", "model fifo_status", fifo_status,
                32'(rxq.size()) | (32'(txq.size()) << 16));
            chk("R8", "model irq_status", irq_status, m_sts);
            chk("R10", "model irq", {31'd0, irq}, {31'd0, |(m_sts & m_en)});
            chk("R2", "model tx head", {24'd0, shf_tx_data},
                {24'd0, (txq.size() > 0) ? txq[0] : 8'd0});
            chk("R2", "model rx head", {24'd0, host_rd_data},
                {24'd0, (rxq.size() > 0) ? rxq[0] : 8'd0});
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle();
        host_wr_en = 0; host_rd_en = 0; shf_tx_take = 0; shf_rx_put = 0;
        xfer_done = 0; tx_flush = 0; rx_flush = 0; irq_en_wr = 0; sts_clr_wr = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            bad++;
            total++;
            $display("FAIL R2 watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk("R1", "reset fifo_status", fifo_status, 32'h0);
        chk("R1", "reset irq_status", irq_status, 32'h0);
        chk("R1", "reset irq", {31'd0, irq}, 32'h0);
        rst_n = 1;
        cyc();
        chk("R6", "tx low flag after reset", irq_status, 32'h0000_1000);

        // R10: enable mask
        irq_en_wr = 1; irq_en_data = 32'hFFFF_FFFF; cyc();
        chk("R10", "irq with tx flag enabled", {31'd0, irq}, 32'h1);
        irq_en_wr = 1; irq_en_data = 32'h0; cyc();
        chk("R10", "irq masked", {31'd0, irq}, 32'h0);

        // R2/R3: fill outbound queue with 65 writes
        for (int k = 0; k < 65; k++) begin
            host_wr_en = 1; host_wr_data = 8'(k * 3 + 1); cyc();
        end
        chk("R3", "tx count after overfill", fifo_status, 32'h0040_0000);
        sts_clr_wr = 1; sts_clr_data = 32'h0000_1000; cyc();
        chk("R8", "tx flag cleared above threshold", irq_status, 32'h0);

        for (int k = 0; k < 48; k++) begin
            chk("R2", "tx order", {24'd0, shf_tx_data}, {24'd0, 8'(k * 3 + 1)});
            shf_tx_take = 1; cyc();
        end
        chk("R6", "tx flag not yet at 16", {31'd0, irq_status[12]}, 32'h0);
        cyc();
        chk("R6", "tx flag at 16", {31'd0, irq_status[12]}, 32'h1);
        for (int k = 48; k < 64; k++) begin
            chk("R2", "tx order tail", {24'd0, shf_tx_data}, {24'd0, 8'(k * 3 + 1)});
            shf_tx_take = 1; cyc();
        end
        shf_tx_take = 1; cyc();
        chk("R3", "take on empty tx", fifo_status, 32'h0);
        chk("R3", "empty tx head zero", {24'd0, shf_tx_data}, 32'h0);

        // R5: inbound threshold
        for (int k = 0; k < 47; k++) begin
            shf_rx_put = 1; shf_rx_data = 8'(100 + k); cyc();
        end
        chk("R5", "rx flag below 48", {31'd0, irq_status[4]}, 32'h0);
        shf_rx_put = 1; shf_rx_data = 8'(147); cyc();
        chk("R5", "rx flag edge of 48", {31'd0, irq_status[4]}, 32'h0);
        cyc();
        chk("R5", "rx flag set", {31'd0, irq_status[4]}, 32'h1);
        sts_clr_wr = 1; sts_clr_data = 32'h0000_0010; cyc();
        chk("R8", "rx flag cleared", {31'd0, irq_status[4]}, 32'h0);
        cyc();
        chk("R8", "rx flag returns", {31'd0, irq_status[4]}, 32'h1);

        // R7: completion
        xfer_done = 1; cyc();
        chk("R7", "done set", {31'd0, irq_status[16]}, 32'h1);
        xfer_done = 1; sts_clr_wr = 1; sts_clr_data = 32'h0001_0000; cyc();
        chk("R7", "done beats clear", {31'd0, irq_status[16]}, 32'h1);
        sts_clr_wr = 1; sts_clr_data = 32'h0001_0000; cyc();
        chk("R8", "done cleared", {31'd0, irq_status[16]}, 32'h0);

        irq_en_wr = 1; irq_en_data = 32'h0001_0000; cyc();
        chk("R10", "irq low with unmasked flags off", {31'd0, irq}, 32'h0);
        xfer_done = 1; cyc();
        chk("R10", "irq from done", {31'd0, irq}, 32'h1);
        sts_clr_wr = 1; sts_clr_data = 32'hFFFF_FFFF; cyc();
        chk("R8", "clear all", irq_status, 32'h0);
        chk("R10", "irq after clear all", {31'd0, irq}, 32'h0);
        cyc();
        chk("R8", "level flags return", irq_status, 32'h0000_1010);

        // R2: host reads
        chk("R2", "rx head first", {24'd0, host_rd_data}, 32'd100);
        host_rd_en = 1; cyc();
        chk("R2", "rx head second", {24'd0, host_rd_data}, 32'd101);
        host_rd_en = 1; cyc();
        chk("R4", "rx count 46", fifo_status, 32'd46);
        host_rd_en = 1; shf_rx_put = 1; shf_rx_data = 8'hEE; cyc();
        chk("R11", "balanced count", fifo_status, 32'd46);
        chk("R11", "balanced head", {24'd0, host_rd_data}, 32'd103);

        for (int k = 0; k < 5; k++) begin
            host_wr_en = 1; host_wr_data = 8'(k); cyc();
        end
        chk("R4", "both counts", fifo_status, 32'h0005_002E);
        rx_flush = 1; cyc();
        chk("R9", "rx flush only", fifo_status, 32'h0005_0000);
        tx_flush = 1; host_wr_en = 1; host_wr_data = 8'h55; cyc();
        chk("R9", "tx flush beats write", fifo_status, 32'h0);
        chk("R3", "empty rx head zero", {24'd0, host_rd_data}, 32'h0);
        host_rd_en = 1; cyc();
        chk("R3", "read on empty rx", fifo_status, 32'h0);

        // Mixed traffic checked by the model each cycle
        for (int n = 0; n < 4000; n++) begin
            host_wr_en   = ($urandom_range(0, 99) < 55);
            host_wr_data = 8'($urandom);
            shf_tx_take  = ($urandom_range(0, 99) < 45);
            shf_rx_put   = ($urandom_range(0, 99) < 55);
            shf_rx_data  = 8'($urandom);
            host_rd_en   = ($urandom_range(0, 99) < 45);
            xfer_done    = ($urandom_range(0, 99) < 3);
            tx_flush     = ($urandom_range(0, 999) < 4);
            rx_flush     = ($urandom_range(0, 999) < 4);
            irq_en_wr    = ($urandom_range(0, 99) < 2);
            irq_en_data  = $urandom;
            sts_clr_wr   = ($urandom_range(0, 99) < 5);
            sts_clr_data = $urandom;
            cyc();
        end

        fin = 1;
        summary();
        $finish;
    end

endmodule